// File: doc/BRIEF.md
# Barrel Shifter with Shifter Carry-Out

This block forms the shifted second operand for a RISC data-processing datapath, together with the carry-out the shift produces. It accepts a data word, a two-bit shift kind, a shift amount and the current carry flag. A mode input chooses how the amount is read. In immediate mode only the low five bits of the amount are used, and a zero amount has a meaning that depends on the kind. In register mode the whole eight-bit amount, taken from the low byte of a register, is used, and amounts of 32 or more follow their own rules.

The result and the carry-out are registered. Both appear one clock after the inputs are presented, ready for the ALU stage that consumes them. Operand fetch, flag storage and the ALU itself are outside this block.

Top module: `shift_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `shifted` and `carry_out` become 0 at that edge. Otherwise both outputs show, one clock later, the function of the inputs sampled at the edge.
- R2: `shift_kind` encodes 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. For a shift by n in 1..31, the result is the plain shift or rotate, and arithmetic right fills with bit 31. The carry-out is bit n-1 of the data for right shifts and rotates, and bit 32-n for a left shift.
- R3: In immediate mode (`amt_from_reg`=0), a logical left shift by 0 passes the data through unchanged and the carry-out equals `carry_in`.
- R4: In immediate mode, a logical right shift by 0 acts as a shift by 32. The result is 0 and the carry-out is data bit 31.
- R5: In immediate mode, an arithmetic right shift by 0 fills all result bits with data bit 31, and the carry-out is data bit 31.
- R6: In immediate mode, a rotate by 0 rotates right by one bit through the carry. The result is {`carry_in`, data[31:1]} and the carry-out is data bit 0.
- R7: In immediate mode, bits [7:5] of `shift_amt` are ignored. Only bits [4:0] give the amount.
- R8: In register mode (`amt_from_reg`=1), an amount of 0 passes the data through unchanged for every kind, and the carry-out equals `carry_in`.
- R9: In register mode, logical left and logical right shifts by 32 or more give a result of 0. At exactly 32 the carry-out is bit 0 for a left shift and bit 31 for a right shift. Above 32 the carry-out is 0.
- R10: In register mode, an arithmetic right shift by 32 or more fills the result with data bit 31, and the carry-out is data bit 31.
- R11: In register mode, a rotate uses the amount modulo 32. A nonzero amount whose residue is 0 leaves the data unchanged and gives data bit 31 as the carry-out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_data | input | 32 | Data word to shift |
| shift_kind | input | 2 | Shift kind (0 LSL, 1 LSR, 2 ASR, 3 ROR) |
| shift_amt | input | 8 | Shift amount (low register byte, or an immediate in bits [4:0]) |
| amt_from_reg | input | 1 | 1 = register-amount mode, 0 = immediate mode |
| carry_in | input | 1 | Current carry flag |
| shifted | output | 32 | Registered shift result |
| carry_out | output | 1 | Registered shifter carry-out |

## Verification
The block holds no state beyond its output registers, so any decode error is visible at the ports on the very next clock after the input pattern that triggers it. A wrong amount decode shows most clearly at the boundaries: zero immediate amounts, register amounts of 31, 32 and 33, and rotate amounts that are multiples of 32. At these points the result or the carry moves to a different data bit, or to `carry_in`. The bench therefore compares every cycle against a behavioural model and drives every kind in both modes across these boundary amounts, as well as random patterns.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;

  typedef enum logic [1:0] {
    SHK_LSL = 2'd0,
    SHK_LSR = 2'd1,
    SHK_ASR = 2'd2,
    SHK_ROR = 2'd3
  } shift_kind_e;

  typedef enum logic [1:0] {
    SHM_PASS  = 2'd0,
    SHM_RRX   = 2'd1,
    SHM_SHIFT = 2'd2
  } shift_mode_e;

endpackage

// File: rtl/shift_amt_decode.sv
// Normalises immediate/register amounts into one canonical operation:
// pass-through, rotate-through-carry, or a shift by n (n may exceed DATA_W).
module shift_amt_decode
  import shift_unit_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_AMT_W = 8,
  localparam int SH_W     = $clog2(DATA_W),
  localparam int N_W      = $clog2(DATA_W + 2)
) (
  input  shift_kind_e          kind,
  input  logic [REG_AMT_W-1:0] amt,
  input  logic                 from_reg,
  output shift_mode_e          mode,
  output logic [N_W-1:0]       n
);

  localparam logic [REG_AMT_W-1:0] FULL = REG_AMT_W'(DATA_W);

  logic [SH_W-1:0] imm_n;
  logic [SH_W-1:0] rot_res;

  assign imm_n   = amt[SH_W-1:0];
  assign rot_res = amt[SH_W-1:0];

  always_comb begin
    mode = SHM_SHIFT;
    n    = '0;
    if (!from_reg) begin
      if (imm_n == '0) begin
        unique case (kind)
          SHK_LSL: mode = SHM_PASS;
          SHK_ROR: mode = SHM_RRX;
          default: n = N_W'(DATA_W);
        endcase
      end else begin
        n = N_W'(imm_n);
      end
    end else if (amt == '0) begin
      mode = SHM_PASS;
    end else begin
      unique case (kind)
        SHK_LSL, SHK_LSR: n = (amt > FULL) ? N_W'(DATA_W + 1) : N_W'(amt);
        SHK_ASR:          n = (amt >= FULL) ? N_W'(DATA_W) : N_W'(amt);
        default:          n = (rot_res == '0) ? N_W'(DATA_W) : N_W'(rot_res);
      endcase
    end
  end

endmodule

// File: rtl/shift_core.sv
// Combinational shifter on a canonical operation. Each shift runs on a
// widened word so the carry falls out as the bit just past the result.
module shift_core
  import shift_unit_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int N_W   = $clog2(DATA_W + 2),
  localparam int WW    = 2 * DATA_W + 2
) (
  input  logic [DATA_W-1:0] data,
  input  shift_kind_e       kind,
  input  shift_mode_e       mode,
  input  logic [N_W-1:0]    n,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);

  logic          fill;
  logic [WW-1:0] left_w;
  logic [WW-1:0] right_w;
  logic [WW-1:0] rot_w;

  assign fill    = (kind == SHK_ASR) & data[DATA_W-1];
  // Left: {zeros, data}; bit DATA_W after the shift is the carry.
  assign left_w  = {{(DATA_W + 2){1'b0}}, data} << n;
  // Right: {fill, data, guard}; the guard bit after the shift is the carry.
  assign right_w = {{(DATA_W + 1){fill}}, data, 1'b0} >> n;
  // Rotate: {pad, data, data, guard}; n in 1..DATA_W.
  assign rot_w   = {1'b0, data, data, 1'b0} >> n;

  always_comb begin
    res  = data;
    cout = cin;
    unique case (mode)
      SHM_RRX: begin
        res  = {cin, data[DATA_W-1:1]};
        cout = data[0];
      end
      SHM_SHIFT: begin
        unique case (kind)
          SHK_LSL: begin
            res  = left_w[DATA_W-1:0];
            cout = left_w[DATA_W];
          end
          SHK_ROR: begin
            res  = rot_w[DATA_W:1];
            cout = rot_w[0];
          end
          default: begin
            res  = right_w[DATA_W:1];
            cout = right_w[0];
          end
        endcase
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_unit_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_AMT_W = 8,
  localparam int N_W      = $clog2(DATA_W + 2)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DATA_W-1:0]    src_data,
  input  logic [1:0]           shift_kind,
  input  logic [REG_AMT_W-1:0] shift_amt,
  input  logic                 amt_from_reg,
  input  logic                 carry_in,
  output logic [DATA_W-1:0]    shifted,
  output logic                 carry_out
);

  shift_kind_e       kind;
  shift_mode_e       mode;
  logic [N_W-1:0]    n;
  logic [DATA_W-1:0] res_c;
  logic              cout_c;

  assign kind = shift_kind_e'(shift_kind);

  shift_amt_decode #(.DATA_W(DATA_W), .REG_AMT_W(REG_AMT_W)) u_dec (
    .kind     (kind),
    .amt      (shift_amt),
    .from_reg (amt_from_reg),
    .mode     (mode),
    .n        (n)
  );

  shift_core #(.DATA_W(DATA_W)) u_core (
    .data (src_data),
    .kind (kind),
    .mode (mode),
    .n    (n),
    .cin  (carry_in),
    .res  (res_c),
    .cout (cout_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      shifted   <= '0;
      carry_out <= 1'b0;
    end else begin
      shifted   <= res_c;
      carry_out <= cout_c;
    end
  end

endmodule

// File: rtl/shift_unit_checker.sv
module shift_unit_checker #(
  parameter int DATA_W    = 32,
  parameter int REG_AMT_W = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [DATA_W-1:0]    src_data,
  input logic [1:0]           shift_kind,
  input logic [REG_AMT_W-1:0] shift_amt,
  input logic                 amt_from_reg,
  input logic                 carry_in,
  input logic [DATA_W-1:0]    shifted,
  input logic                 carry_out
);

  localparam int SH_W = $clog2(DATA_W);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (shifted == '0 && carry_out == 1'b0));

  assert_imm_lsr_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (!amt_from_reg && shift_kind == 2'd1 && shift_amt[SH_W-1:0] == '0)
    |=> (shifted == '0 && carry_out == $past(src_data[DATA_W-1])));

  assert_imm_rrx_R6: assert property (@(posedge clk) disable iff (rst)
    (!amt_from_reg && shift_kind == 2'd3 && shift_amt[SH_W-1:0] == '0)
    |=> (shifted == {$past(carry_in), $past(src_data[DATA_W-1:1])}
         && carry_out == $past(src_data[0])));

  assert_reg_zero_pass_R8: assert property (@(posedge clk) disable iff (rst)
    (amt_from_reg && shift_amt == '0)
    |=> (shifted == $past(src_data) && carry_out == $past(carry_in)));

  assert_reg_logic_big_R9: assert property (@(posedge clk) disable iff (rst)
    (amt_from_reg && !shift_kind[1] && shift_amt > REG_AMT_W'(DATA_W))
    |=> (shifted == '0 && carry_out == 1'b0));

  assert_reg_asr_big_R10: assert property (@(posedge clk) disable iff (rst)
    (amt_from_reg && shift_kind == 2'd2 && shift_amt >= REG_AMT_W'(DATA_W))
    |=> (shifted == {DATA_W{$past(src_data[DATA_W-1])}}
         && carry_out == $past(src_data[DATA_W-1])));

  assert_reg_ror_wrap_R11: assert property (@(posedge clk) disable iff (rst)
    (amt_from_reg && shift_kind == 2'd3 && shift_amt != '0
     && shift_amt[SH_W-1:0] == '0)
    |=> (shifted == $past(src_data) && carry_out == $past(src_data[DATA_W-1])));

endmodule

bind shift_unit shift_unit_checker #(.DATA_W(DATA_W), .REG_AMT_W(REG_AMT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .src_data     (src_data),
  .shift_kind   (shift_kind),
  .shift_amt    (shift_amt),
  .amt_from_reg (amt_from_reg),
  .carry_in     (carry_in),
  .shifted      (shifted),
  .carry_out    (carry_out)
);

// File: tb/sim_shift_unit.sv
`timescale 1ns/1ps
module sim_shift_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_data = '0;
  logic [1:0]  shift_kind = '0;
  logic [7:0]  shift_amt = '0;
  logic        amt_from_reg = 1'b0;
  logic        carry_in = 1'b0;
  logic [31:0] shifted;
  logic        carry_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  shift_unit u0 (
    .clk(clk), .rst(rst), .src_data(src_data), .shift_kind(shift_kind),
    .shift_amt(shift_amt), .amt_from_reg(amt_from_reg), .carry_in(carry_in),
    .shifted(shifted), .carry_out(carry_out)
  );

  // Behavioural reference: returns {carry, result}.
  function automatic logic [32:0] model(input logic [31:0] d, input int ty,
                                        input logic [7:0] a, input bit rm,
                                        input bit ci);
    int k;
    logic [31:0] r;
    logic c;
    k = rm ? int'(a) : int'(a[4:0]);
    r = d; c = ci;
    if (!rm) begin
      case (ty)
        0: if (k != 0) begin r = d << k; c = d[32-k]; end
        1: begin if (k == 0) k = 32; r = (k >= 32) ? 32'd0 : d >> k; c = d[k-1]; end
        2: begin if (k == 0) k = 32; r = 32'($signed(d) >>> k); c = d[k-1]; end
        default: if (k == 0) begin r = {ci, d[31:1]}; c = d[0]; end
                 else begin r = (d >> k) | (d << (32 - k)); c = d[k-1]; end
      endcase
    end else if (k != 0) begin
      case (ty)
        0: if (k < 32) begin r = d << k; c = d[32-k]; end
           else begin r = 0; c = (k == 32) ? d[0] : 1'b0; end
        1: if (k < 32) begin r = d >> k; c = d[k-1]; end
           else begin r = 0; c = (k == 32) ? d[31] : 1'b0; end
        2: if (k < 32) begin r = 32'($signed(d) >>> k); c = d[k-1]; end
           else begin r = {32{d[31]}}; c = d[31]; end
        default: begin
          k = k % 32;
          if (k == 0) begin r = d; c = d[31]; end
          else begin r = (d >> k) | (d << (32 - k)); c = d[k-1]; end
        end
      endcase
    end
    return {c, r};
  endfunction

  function automatic string tag(input int ty, input logic [7:0] a, input bit rm);
    int k;
    if (!rm) begin
      if (a[7:5] != 0) return "R7";
      if (a[4:0] != 0) return "R2";
      case (ty) 0: return "R3"; 1: return "R4"; 2: return "R5"; default: return "R6"; endcase
    end
    k = int'(a);
    if (k == 0) return "R8";
    if (ty == 3) return (k % 32 == 0) ? "R11" : "R2";
    if (k >= 32) return (ty == 2) ? "R10" : "R9";
    return "R2";
  endfunction

  // Apply inputs at negedge, check at the next negedge (one register).
  task automatic apply(input logic [31:0] d, input int ty, input logic [7:0] a,
                       input bit rm, input bit ci);
    logic [32:0] exp;
    string t;
    src_data = d; shift_kind = 2'(ty); shift_amt = a;
    amt_from_reg = rm; carry_in = ci;
    exp = model(d, ty, a, rm, ci);
    t = tag(ty, a, rm);
    @(negedge clk);
    n_tests++;
    if ({carry_out, shifted} !== exp) begin
      n_fail++;
      $display("FAIL %s: ty=%0d amt=%0d reg=%0b cin=%0b d=%h got c=%0b r=%h exp c=%0b r=%h",
               t, ty, a, rm, ci, d, carry_out, shifted, exp[32], exp[31:0]);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [4];
    logic [7:0]  amts [14];
    pats = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hDEAD_BEEF, 32'h0000_0000};
    amts = '{8'd0, 8'd1, 8'd2, 8'd15, 8'd31, 8'd32, 8'd33, 8'd63, 8'd64,
             8'd96, 8'd128, 8'd255, 8'd224, 8'd97};

    // R1: reset clears outputs even with live inputs
    src_data = 32'hFFFF_FFFF; shift_kind = 2'd3; carry_in = 1'b1; amt_from_reg = 1'b1;
    shift_amt = 8'd0;
    repeat (3) @(negedge clk);
    n_tests++;
    if (shifted !== 32'd0 || carry_out !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: got c=%0b r=%h exp c=0 r=00000000", carry_out, shifted);
    end
    rst = 1'b0;

    // Directed sweep: every kind, both modes, boundary amounts, both carries
    for (int p = 0; p < 4; p++)
      for (int ty = 0; ty < 4; ty++)
        for (int m = 0; m < 2; m++)
          for (int ai = 0; ai < 14; ai++)
            for (int ci = 0; ci < 2; ci++)
              apply(pats[p], ty, amts[ai], m[0], ci[0]);

    // Random patterns
    for (int i = 0; i < 3000; i++)
      apply($urandom, int'($urandom % 4), 8'($urandom), 1'($urandom), 1'($urandom));

    // R1 again: reset mid-run
    rst = 1'b1;
    @(negedge clk);
    n_tests++;
    if (shifted !== 32'd0 || carry_out !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: got c=%0b r=%h exp c=0 r=00000000", carry_out, shifted);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule